// File: doc/BRIEF.md
# Streaming Hamming ECC Generator for Page Data

This block computes a page-style Hamming code (line parity plus column parity) on bytes as they pass across a parallel data path. It watches a byte bus with a valid strobe and folds every accepted byte into a running code, so the code is ready the moment the last byte of a block has gone by. No extra pass over the data is needed.

Two block sizes are supported. In split mode the stream is treated as two consecutive 256-byte blocks, each with its own three-byte code. In joined mode the same 512 bytes form one block whose line parity is two bits wider. A one-cycle clear strobe zeroes both codes, rewinds the byte count and samples the mode input. After 512 accepted bytes the block freezes until the next clear. Checking and correcting data against a stored code is left to other logic.

Top module: `ecc_stream_gen`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), all six code bytes read zero and split mode is selected.
- R2: A cycle with clr_i high zeroes all six code bytes, rewinds the byte count to zero and samples mode_i. A byte presented with valid_i in that same cycle is not counted.
- R3: A byte is accumulated only at a clock edge where valid_i is high and clr_i is low. With valid_i low, the code bytes do not change, whatever value data_i has.
- R4: Line parity uses one pair of bits per address bit k of the byte's position inside its block. Bit 2k+1 is the XOR of the parities of bytes whose address bit k is 1, and bit 2k is the same for bytes whose address bit k is 0. The lp_lo byte holds line bits 7..0 and the lp_hi byte holds line bits 15..8.
- R5: Column parity bits c0..c5 are the XOR, over every byte of the block, of these data bit groups: c0 = bits {0,2,4,6}, c1 = {1,3,5,7}, c2 = {0,1,4,5}, c3 = {2,3,6,7}, c4 = {0,1,2,3}, c5 = {4,5,6,7}. The cp byte holds c5..c0 in bits 7..2.
- R6: In split mode (mode_i = 0 at the clear), accepted bytes 0..255 feed set 0 and bytes 256..511 feed set 1. Each set uses an 8-bit address that starts at 0 for its block, and cp bits 1..0 of both sets read zero.
- R7: In joined mode (mode_i = 1 at the clear), all 512 bytes feed set 0 with a 9-bit address. Line bits 17..16 appear in set 0 cp bits 1..0, and all set 1 bytes stay zero.
- R8: Once 512 bytes have been accepted since the last clear, further valid bytes are ignored and the code bytes hold until the next clear.
- R9: mode_i is sampled only in a clear cycle. Changes at other times have no effect on the running calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 8 | Byte on the data path |
| valid_i | input | 1 | Byte transfer strobe |
| clr_i | input | 1 | Clear and restart strobe |
| mode_i | input | 1 | 0: two 256-byte codes, 1: one 512-byte code (sampled at clear) |
| res0_lp_lo_o | output | 8 | Set 0 line parity bits 7..0 |
| res0_lp_hi_o | output | 8 | Set 0 line parity bits 15..8 |
| res0_cp_o | output | 8 | Set 0 column parity (7..2), line bits 17..16 in joined mode (1..0) |
| res1_lp_lo_o | output | 8 | Set 1 line parity bits 7..0 |
| res1_lp_hi_o | output | 8 | Set 1 line parity bits 15..8 |
| res1_cp_o | output | 8 | Set 1 column parity (7..2), bits 1..0 zero |

## Verification
The assertions assume that data_i, valid_i, clr_i and mode_i are known values at every clock edge after reset. They also assume that reset is held across at least one edge before any transfer. They do not constrain how often clr_i or mode_i change, so mode toggling outside clear cycles, a clear in the middle of a block, and a clear that lands on a valid byte are all legal. The stimulus drives every input on the falling edge with defined values. It exercises exactly these cases, along with gaps in valid_i and bytes offered after the 512-byte limit.

// File: rtl/ecc_stream_pkg.sv
// Shared sizes and types for the streaming ECC generator.
// Assumes byte-wide data and a 256-byte base block, as the result
// byte packing depends on a 16-bit split line parity.
package ecc_stream_pkg;
    localparam int BLK_BYTES   = 256;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = $clog2(BLK_BYTES);
    localparam int SPAN_W      = ADDR_W + 1;
    localparam int CNT_W       = ADDR_W + 2;
    localparam int TOTAL_BYTES = 2 * BLK_BYTES;
    localparam int CP_W        = 2 * $clog2(BYTE_W);
    localparam int LP0_W       = 2 * SPAN_W;
    localparam int LP1_W       = 2 * ADDR_W;

    typedef struct packed {
        logic [7:0] cp_b;
        logic [7:0] lp_hi;
        logic [7:0] lp_lo;
    } ecc_bytes_t;
endpackage

// File: rtl/ecc_col_parity.sv
// Combinational per-byte parity terms.
// Produces the byte's overall parity and the paired column parities:
// for each data index bit g, the "high" term XORs data bits whose
// index has bit g set and the "low" term the rest.
module ecc_col_parity
    import ecc_stream_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    output logic [CP_W-1:0]   cp_o,
    output logic              par_o
);
    // Overall parity of the byte, used by line parity.
    assign par_o = ^data_i;

    for (genvar g = 0; g < CP_W / 2; g++) begin : g_grp
        logic hi_x;
        logic lo_x;
        // Split the data bits by index bit g and reduce each half.
        always_comb begin
            hi_x = 1'b0;
            lo_x = 1'b0;
            for (int b = 0; b < BYTE_W; b++) begin
                if (((b >> g) & 1) == 1) hi_x = hi_x ^ data_i[b];
                else                     lo_x = lo_x ^ data_i[b];
            end
        end
        assign cp_o[2*g]   = lo_x;
        assign cp_o[2*g+1] = hi_x;
    end
endmodule

// File: rtl/ecc_set_accum.sv
// One result set: line-parity pairs over AW address bits plus column
// parity, XOR-accumulated on each enabled byte.
// Assumes clr_i has priority over en_i and that addr_i is the byte
// position within this set's block.
module ecc_set_accum
    import ecc_stream_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic            par_i,
    input  logic [CP_W-1:0] cp_i,
    output logic [2*AW-1:0] lp_o,
    output logic [CP_W-1:0] cp_o
);
    logic [2*AW-1:0] lp_q;
    logic [2*AW-1:0] lp_d;
    logic [CP_W-1:0] cp_q;

    // Fold the byte parity into one member of each address-bit pair.
    always_comb begin
        lp_d = lp_q;
        for (int k = 0; k < AW; k++) begin
            if (addr_i[k]) lp_d[2*k+1] = lp_q[2*k+1] ^ par_i;
            else           lp_d[2*k]   = lp_q[2*k]   ^ par_i;
        end
    end

    // Hold, clear or accumulate the set's parity state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lp_q <= '0;
            cp_q <= '0;
        end else if (en_i) begin
            lp_q <= lp_d;
            cp_q <= cp_q ^ cp_i;
        end
    end

    assign lp_o = lp_q;
    assign cp_o = cp_q;

    // R3: without an enable or clear the set keeps its value
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(lp_q) && $stable(cp_q)));
endmodule

// File: rtl/ecc_byte_sequencer.sv
// Counts accepted bytes, latches the block mode on clear, routes each
// byte to a result set and stops after the full span.
// Assumes a single clear cycle restarts a run; clear wins over valid.
module ecc_byte_sequencer
    import ecc_stream_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              valid_i,
    input  logic              mode_i,
    output logic              mode_o,
    output logic [1:0]        en_o,
    output logic [SPAN_W-1:0] addr_o,
    output logic              done_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TOTAL_BYTES);

    logic [CNT_W-1:0] cnt_q;
    logic             mode_q;
    logic             take;

    assign done_o = (cnt_q == LIMIT);
    assign take   = valid_i && !clr_i && !done_o;

    // Byte counter: rewinds on clear, advances per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  cnt_q <= '0;
        else if (take)        cnt_q <= cnt_q + 1'b1;
    end

    // Mode register: sampled only in a clear cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= 1'b0;
        else if (clr_i) mode_q <= mode_i;
    end

    // Route the byte: joined mode always set 0, split mode by block half.
    always_comb begin
        en_o[0] = take && (mode_q || !cnt_q[ADDR_W]);
        en_o[1] = take && !mode_q && cnt_q[ADDR_W];
    end

    assign addr_o = cnt_q[SPAN_W-1:0];
    assign mode_o = mode_q;

    // R3: each accepted byte advances the count by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clr_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R8: a full run holds its count until cleared
    p_hold_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> $stable(cnt_q));
    // R2: clear rewinds the count
    p_clear_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    // R9: mode does not move outside a clear cycle
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> $stable(mode_q));
    // R6: a byte never feeds both sets
    p_one_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_o));
endmodule

// File: rtl/ecc_stream_gen.sv
// Top of the streaming ECC generator. Derives per-byte parity terms,
// sequences bytes into two result sets and packs each set into three
// readable bytes.
// Assumes inputs are synchronous to clk and known after reset.
module ecc_stream_gen
    import ecc_stream_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    input  logic       clr_i,
    input  logic       mode_i,
    output logic [7:0] res0_lp_lo_o,
    output logic [7:0] res0_lp_hi_o,
    output logic [7:0] res0_cp_o,
    output logic [7:0] res1_lp_lo_o,
    output logic [7:0] res1_lp_hi_o,
    output logic [7:0] res1_cp_o
);
    logic [CP_W-1:0]   byte_cp;
    logic              byte_par;
    logic              mode_q;
    logic [1:0]        set_en;
    logic [SPAN_W-1:0] addr;
    logic              full;
    logic [LP0_W-1:0]  lp0;
    logic [LP1_W-1:0]  lp1;
    logic [CP_W-1:0]   cp0;
    logic [CP_W-1:0]   cp1;
    ecc_bytes_t        set0;
    ecc_bytes_t        set1;

    ecc_col_parity u_terms (
        .data_i (data_i),
        .cp_o   (byte_cp),
        .par_o  (byte_par)
    );

    ecc_byte_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .valid_i (valid_i),
        .mode_i  (mode_i),
        .mode_o  (mode_q),
        .en_o    (set_en),
        .addr_o  (addr),
        .done_o  (full)
    );

    ecc_set_accum #(.AW(SPAN_W)) u_set0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .en_i   (set_en[0]),
        .addr_i (addr),
        .par_i  (byte_par),
        .cp_i   (byte_cp),
        .lp_o   (lp0),
        .cp_o   (cp0)
    );

    ecc_set_accum #(.AW(ADDR_W)) u_set1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .en_i   (set_en[1]),
        .addr_i (addr[ADDR_W-1:0]),
        .par_i  (byte_par),
        .cp_i   (byte_cp),
        .lp_o   (lp1),
        .cp_o   (cp1)
    );

    // Pack set 0; the two top line bits only show in joined mode.
    always_comb begin
        set0.lp_lo = lp0[7:0];
        set0.lp_hi = lp0[15:8];
        set0.cp_b  = {cp0, (mode_q ? lp0[LP0_W-1:LP1_W] : 2'b00)};
    end

    // Pack set 1; its low two bits are unused.
    always_comb begin
        set1.lp_lo = lp1[7:0];
        set1.lp_hi = lp1[15:8];
        set1.cp_b  = {cp1, 2'b00};
    end

    assign res0_lp_lo_o = set0.lp_lo;
    assign res0_lp_hi_o = set0.lp_hi;
    assign res0_cp_o    = set0.cp_b;
    assign res1_lp_lo_o = set1.lp_lo;
    assign res1_lp_hi_o = set1.lp_hi;
    assign res1_cp_o    = set1.cp_b;

    // R2: a clear leaves all six bytes at zero
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ({res0_lp_lo_o, res0_lp_hi_o, res0_cp_o,
                    res1_lp_lo_o, res1_lp_hi_o, res1_cp_o} == 48'h0));
    // R7: joined mode never touches set 1
    p_set1_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> ({res1_lp_lo_o, res1_lp_hi_o, res1_cp_o} == 24'h0));
    // R8: after the full span the outputs freeze
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr_i) |=> ($stable(set0) && $stable(set1)));
    // R6: set 1 stays put while split mode is still in the first block
    p_set1_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !clr_i && !addr[ADDR_W] && !full) |=> $stable(set1));
endmodule

// File: tb/ecc_stream_gen_tb_top.sv
// Bench: behavioural reference model (byte log since the last clear)
// recomputed from scratch and compared against the outputs every clock.
module ecc_stream_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       valid_i = 1'b0;
    logic       clr_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] r0_lo, r0_hi, r0_cp, r1_lo, r1_hi, r1_cp;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    bit    closed  = 0;
    string cur_req = "R1";

    // reference model state
    int   log_b [0:511];
    int   n_acc = 0;
    bit   m_mode = 0;
    logic [47:0] exp_v;

    always #4 clk = ~clk;

    ecc_stream_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_i       (data_i),
        .valid_i      (valid_i),
        .clr_i        (clr_i),
        .mode_i       (mode_i),
        .res0_lp_lo_o (r0_lo),
        .res0_lp_hi_o (r0_hi),
        .res0_cp_o    (r0_cp),
        .res1_lp_lo_o (r1_lo),
        .res1_lp_hi_o (r1_hi),
        .res1_cp_o    (r1_cp)
    );

    function automatic logic [5:0] col_of(input int d);
        logic [7:0] b = d[7:0];
        return {^(b & 8'hF0), ^(b & 8'h0F), ^(b & 8'hCC),
                ^(b & 8'h33), ^(b & 8'hAA), ^(b & 8'h55)};
    endfunction

    // Recompute both codes from the logged bytes (R4, R5, R6, R7).
    task automatic compute_expected();
        logic [17:0] lpa = '0;
        logic [15:0] lpb = '0;
        logic [5:0]  cpa = '0;
        logic [5:0]  cpb = '0;
        for (int i = 0; i < n_acc; i++) begin
            logic p = ^log_b[i][7:0];
            if (m_mode || i < 256) begin
                int nb = m_mode ? 9 : 8;
                for (int k = 0; k < nb; k++) lpa[2*k + ((i >> k) & 1)] ^= p;
                cpa ^= col_of(log_b[i]);
            end else begin
                int a = i - 256;
                for (int k = 0; k < 8; k++) lpb[2*k + ((a >> k) & 1)] ^= p;
                cpb ^= col_of(log_b[i]);
            end
        end
        exp_v = {lpa[7:0], lpa[15:8], cpa, (m_mode ? lpa[17:16] : 2'b00),
                 lpb[7:0], lpb[15:8], cpb, 2'b00};
    endtask

    task automatic check_now();
        logic [47:0] got = {r0_lo, r0_hi, r0_cp, r1_lo, r1_hi, r1_cp};
        compute_expected();
        n_tests++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (bytes accepted %0d)",
                     cur_req, got, exp_v, n_acc);
        end
    endtask

    // One clock: compare the previous edge's result, then drive and model.
    task automatic step(input bit clr, input bit vld, input int d, input bit md);
        @(negedge clk);
        check_now();
        clr_i = clr; valid_i = vld; data_i = d[7:0]; mode_i = md;
        if (clr) begin
            n_acc = 0;
            m_mode = md;
        end else if (vld && n_acc < 512) begin
            log_b[n_acc] = d;
            n_acc++;
        end
    endtask

    task automatic run_bytes(input int count, input int seed, input bit md, input bit toggle_mode);
        int sent = 0;
        int cyc = 0;
        while (sent < count) begin
            bit v = (cyc % 5) != 3;
            bit mm = toggle_mode ? ((cyc / 7) % 2 == 0) : md;
            step(1'b0, v, (sent * 37 + seed * 11 + cyc) & 255, mm);
            if (v) sent++;
            cyc++;
        end
    endtask

    task automatic fixed_check(input string req, input logic [47:0] want);
        logic [47:0] got = {r0_lo, r0_hi, r0_cp, r1_lo, r1_hi, r1_cp};
        n_tests++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    task automatic finish_run();
        if (!closed) begin
            closed = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got %0d cycles expected below 100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        step(0, 0, 8'hA5, 0);
        step(0, 0, 8'h3C, 0);
        fixed_check("R1", 48'h0);
        // R4,R5: one byte 0x01 at address 0 in split mode
        cur_req = "R4,R5";
        step(1, 0, 0, 0);
        step(0, 1, 8'h01, 0);
        step(0, 0, 8'hFF, 1);
        fixed_check("R4,R5", {8'h55, 8'h55, 8'h54, 24'h0});
        // R3: idle cycles with changing data leave codes unchanged
        cur_req = "R3";
        for (int i = 0; i < 6; i++) step(0, 0, i * 29, i[0]);
        fixed_check("R3", {8'h55, 8'h55, 8'h54, 24'h0});
        // R2: clear with a valid byte in the same cycle
        cur_req = "R2";
        step(1, 1, 8'hFF, 0);
        step(0, 0, 0, 0);
        fixed_check("R2", 48'h0);
        // R6: full split-mode run with gaps
        cur_req = "R6";
        run_bytes(512, 1, 0, 0);
        // R8: extra bytes after the limit are ignored
        cur_req = "R8";
        for (int i = 0; i < 20; i++) step(0, 1, i * 53 + 7, 0);
        // R7,R9: joined mode with mode_i toggling during the run
        cur_req = "R7,R9";
        step(1, 0, 0, 1);
        run_bytes(512, 2, 1, 1);
        cur_req = "R8";
        for (int i = 0; i < 20; i++) step(0, 1, i * 19 + 3, 0);
        // R2: clear in the middle of a run, then continue past one block
        cur_req = "R2";
        step(1, 0, 0, 0);
        run_bytes(100, 3, 0, 0);
        step(1, 1, 8'h77, 0);
        cur_req = "R6";
        run_bytes(300, 4, 0, 0);
        // R9: joined run switched to split only by a clear
        cur_req = "R9";
        step(1, 0, 0, 1);
        run_bytes(200, 5, 0, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        finish_run();
    end
endmodule